// File: doc/BRIEF.md
# Banked Command and Interrupt Control Core

This core is the host-side control point of a network adapter. The host writes a 16-bit command word: a 5-bit opcode in bits 15:11 and an 11-bit argument in bits 10:0. The core decodes the word and applies it. It keeps the selected register bank, which neighbouring logic uses to route the other offsets. It also holds the receive enable and the receive filter mode.

The core keeps a latch of pending event bits. Hardware event pulses set these bits, and the host clears them with an acknowledge command. An interrupt enable mask decides which pending bits drive the interrupt line. A separate visibility mask decides which bits show in the status word.

The status word is a registered snapshot. It holds the selected bank, a busy flag that runs for a fixed number of cycles after any reset-type command, and the masked event bits.

Top module: `nic_cmd_core`

## Requirements
- R1: Opcode 1 loads the bank number from argument bits 2:0 into `window_o`. After reset the bank is 0, and status bits 15:13 show the bank.
- R2: The status word has the busy flag in bit 12 and zeros in bits 11:8. Bits 7:0 are the event vector ANDed with the visibility mask, and that mask resets to all ones. The status word is registered and shows the state one clock after that state changes.
- R3: A high `evt_i[k]` (k from 1 to 7) sets pending bit k: 1 adapter failure, 2 TX done, 3 TX room, 4 RX done, 5 RX early, 6 host request, 7 statistics. `evt_i[0]` has no effect. When a set and a clear hit the same bit in the same cycle, the set wins.
- R4: Opcode 13 clears every pending bit k in 7:1 whose argument bit k is 1. It has no effect on bit 0.
- R5: Opcode 14 loads the interrupt enable mask from argument bits 7:1. The mask resets to zero. `irq_o` is a register that goes high one clock after some pending bit in 7:1 is also enabled. Event bit 0 reads the value of `irq_o`.
- R6: Opcode 15 loads the visibility mask from argument bits 7:0.
- R7: Opcode 16 loads `rx_filter_o` from argument bits 3:0: bit 0 own address, bit 1 group, bit 2 all-stations, bit 3 accept-all. The filter resets to 0.
- R8: Opcode 12 sets pending bit 6.
- R9: Receive is disabled after reset. Opcode 3 clears `rx_en_o` and opcode 4 sets it.
- R10: Opcodes 0, 5 and 11 drive `busy_o` high for exactly BUSY_CYCLES cycles, starting the cycle after the command is taken. A new one of these commands restarts the count. At all other times `busy_o` is low.
- R11: Opcode 0 returns the bank, both masks, the pending bits, the filter and the receive enable to their reset values.
- R12: An opcode not listed in R1 to R11 changes no state.
- R13: Argument bits that a command does not use have no effect. For example, opcode 1 ignores bits 10:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command word is valid this cycle |
| cmd_word_i | input | 16 | Opcode in 15:11, argument in 10:0 |
| evt_i | input | 8 | Hardware event pulses, bits 7:1 used |
| window_o | output | 3 | Selected register bank |
| rx_en_o | output | 1 | Receive enable |
| rx_filter_o | output | 4 | Receive filter mode |
| busy_o | output | 1 | Reset-type command in progress |
| irq_o | output | 1 | Interrupt request |
| status_o | output | 16 | Registered status word |

## Verification
The assertions assume that reset is held for at least two cycles. This lets the bank-to-status relation start from defined history. They also assume that `cmd_word_i` and `evt_i` are stable whenever `cmd_valid_i` is sampled. The stimulus changes inputs only at falling edges and keeps each command valid for exactly one cycle. Between checks it leaves several idle cycles, so both the one-cycle and the two-cycle status lags have settled. Some vectors pair an acknowledge with an event on the same bit, to exercise the set-over-clear rule within those limits.

// File: rtl/nic_cmd_pkg.sv
package nic_cmd_pkg;
  localparam int OP_W    = 5;
  localparam int REQ_BIT = 6;

  typedef enum logic [OP_W-1:0] {
    OP_GRESET = 5'd0,
    OP_WINSEL = 5'd1,
    OP_RX_OFF = 5'd3,
    OP_RX_ON  = 5'd4,
    OP_RX_RST = 5'd5,
    OP_TX_RST = 5'd11,
    OP_REQ    = 5'd12,
    OP_ACK    = 5'd13,
    OP_IMASK  = 5'd14,
    OP_RZMASK = 5'd15,
    OP_FILTER = 5'd16
  } nic_op_e;

  typedef struct packed {
    logic greset;
    logic winsel;
    logic rx_off;
    logic rx_on;
    logic busy_start;
    logic req;
    logic ack;
    logic ld_imask;
    logic ld_rzmask;
    logic ld_filter;
  } nic_dec_t;
endpackage

// File: rtl/nic_cmd_decode.sv
module nic_cmd_decode
  import nic_cmd_pkg::*;
(
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  output nic_dec_t        dec_o
);
  always_comb begin
    dec_o = '0;
    if (valid_i) begin
      case (op_i)
        OP_GRESET: begin dec_o.greset = 1'b1; dec_o.busy_start = 1'b1; end
        OP_WINSEL: dec_o.winsel    = 1'b1;
        OP_RX_OFF: dec_o.rx_off    = 1'b1;
        OP_RX_ON:  dec_o.rx_on     = 1'b1;
        OP_RX_RST: dec_o.busy_start = 1'b1;
        OP_TX_RST: dec_o.busy_start = 1'b1;
        OP_REQ:    dec_o.req       = 1'b1;
        OP_ACK:    dec_o.ack       = 1'b1;
        OP_IMASK:  dec_o.ld_imask  = 1'b1;
        OP_RZMASK: dec_o.ld_rzmask = 1'b1;
        OP_FILTER: dec_o.ld_filter = 1'b1;
        default:   dec_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/nic_intr_unit.sv
module nic_intr_unit #(
  parameter int EVT_W   = 8,
  parameter int REQ_BIT = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             req_i,
  input  logic             ack_i,
  input  logic             ld_imask_i,
  input  logic             ld_rzmask_i,
  input  logic [EVT_W-1:0] arg_i,
  output logic [EVT_W-1:1] pend_o,
  output logic [EVT_W-1:1] imask_o,
  output logic [EVT_W-1:0] rzmask_o,
  output logic             irq_o,
  output logic [EVT_W-1:0] vis_o
);
  logic [EVT_W-1:1] pend_q, imask_q, set_v, clr_v;
  logic [EVT_W-1:0] rz_q;
  logic             irq_q;
  logic             unused_evt0;

  assign unused_evt0 = evt_i[0];

  always_comb begin
    set_v = evt_i[EVT_W-1:1];
    if (req_i) set_v[REQ_BIT] = 1'b1;
    clr_v = ack_i ? arg_i[EVT_W-1:1] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      pend_q  <= '0;
      imask_q <= '0;
      rz_q    <= '1;
      irq_q   <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr_v) | set_v;
      if (ld_imask_i)  imask_q <= arg_i[EVT_W-1:1];
      if (ld_rzmask_i) rz_q    <= arg_i;
      irq_q <= |(pend_q & imask_q);
    end
  end

  assign pend_o   = pend_q;
  assign imask_o  = imask_q;
  assign rzmask_o = rz_q;
  assign irq_o    = irq_q;
  assign vis_o    = {pend_q, irq_q} & rz_q;
endmodule

// File: rtl/nic_busy_timer.sv
module nic_busy_timer #(
  parameter int BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (start_i)       cnt_q <= CNT_W'(BUSY_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/nic_cmd_core.sv
module nic_cmd_core
  import nic_cmd_pkg::*;
#(
  parameter int CMD_W       = 16,
  parameter int WIN_W       = 3,
  parameter int EVT_W       = 8,
  parameter int FILT_W      = 4,
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_word_i,
  input  logic [EVT_W-1:0]  evt_i,
  output logic [WIN_W-1:0]  window_o,
  output logic              rx_en_o,
  output logic [FILT_W-1:0] rx_filter_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic [CMD_W-1:0]  status_o
);
  localparam int ARG_W = CMD_W - OP_W;
  localparam int PAD_W = CMD_W - WIN_W - 1 - EVT_W;

  logic [OP_W-1:0]   op;
  logic [ARG_W-1:0]  arg;
  nic_dec_t          dec;
  logic [WIN_W-1:0]  win_q;
  logic              rx_en_q;
  logic [FILT_W-1:0] filt_q;
  logic [CMD_W-1:0]  status_q;
  logic              busy;
  logic              irq;
  logic [EVT_W-1:1]  pend, imask;
  logic [EVT_W-1:0]  rzmask, vis;
  logic              unused_arg_hi;

  assign op  = cmd_word_i[CMD_W-1 -: OP_W];
  assign arg = cmd_word_i[ARG_W-1:0];
  assign unused_arg_hi = ^arg[ARG_W-1:EVT_W];

  nic_cmd_decode u_dec (
    .valid_i (cmd_valid_i),
    .op_i    (op),
    .dec_o   (dec)
  );

  nic_intr_unit #(.EVT_W(EVT_W), .REQ_BIT(REQ_BIT)) u_intr (
    .clk         (clk),
    .rst         (rst),
    .clr_i       (dec.greset),
    .evt_i       (evt_i),
    .req_i       (dec.req),
    .ack_i       (dec.ack),
    .ld_imask_i  (dec.ld_imask),
    .ld_rzmask_i (dec.ld_rzmask),
    .arg_i       (arg[EVT_W-1:0]),
    .pend_o      (pend),
    .imask_o     (imask),
    .rzmask_o    (rzmask),
    .irq_o       (irq),
    .vis_o       (vis)
  );

  nic_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk     (clk),
    .rst     (rst),
    .start_i (dec.busy_start),
    .busy_o  (busy)
  );

  always_ff @(posedge clk) begin
    if (rst || dec.greset) begin
      win_q   <= '0;
      rx_en_q <= 1'b0;
      filt_q  <= '0;
    end else begin
      if (dec.winsel)    win_q   <= arg[WIN_W-1:0];
      if (dec.rx_on)     rx_en_q <= 1'b1;
      if (dec.rx_off)    rx_en_q <= 1'b0;
      if (dec.ld_filter) filt_q  <= arg[FILT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= {win_q, busy, {PAD_W{1'b0}}, vis};
  end

  assign window_o    = win_q;
  assign rx_en_o     = rx_en_q;
  assign rx_filter_o = filt_q;
  assign busy_o      = busy;
  assign irq_o       = irq;
  assign status_o    = status_q;
endmodule

// File: rtl/nic_cmd_checker.sv
module nic_cmd_checker #(
  parameter int CMD_W       = 16,
  parameter int WIN_W       = 3,
  parameter int EVT_W       = 8,
  parameter int FILT_W      = 4,
  parameter int BUSY_CYCLES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid_i,
  input logic [CMD_W-1:0]  cmd_word_i,
  input logic [EVT_W-1:0]  evt_i,
  input logic [WIN_W-1:0]  win,
  input logic              rx_en,
  input logic [FILT_W-1:0] filt,
  input logic              busy,
  input logic [EVT_W-1:1]  pend,
  input logic [EVT_W-1:1]  imask,
  input logic [EVT_W-1:0]  rzmask,
  input logic [CMD_W-1:0]  status
);
  localparam int RUN_W = $clog2(BUSY_CYCLES + 2);
  logic [4:0] op;
  logic       start;
  logic       undef;
  logic [RUN_W-1:0] run_q;

  assign op    = cmd_word_i[CMD_W-1 -: 5];
  assign start = cmd_valid_i && (op == 5'd0 || op == 5'd5 || op == 5'd11);
  assign undef = cmd_valid_i && !(op <= 5'd1 || (op >= 5'd3 && op <= 5'd5) ||
                                  (op >= 5'd11 && op <= 5'd16));

  always_ff @(posedge clk) begin
    if (rst || start) run_q <= '0;
    else if (busy)    run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  p_window_load_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_i && op == 5'd1 |=> win == $past(cmd_word_i[WIN_W-1:0]));

  p_status_bank_r2: assert property (@(posedge clk) disable iff (rst)
    status[CMD_W-1 -: WIN_W] == $past(win));

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_i && op == 5'd13 |=>
      (pend & $past(cmd_word_i[EVT_W-1:1] & ~evt_i[EVT_W-1:1])) == '0);

  p_rx_on_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_i && op == 5'd4 |=> rx_en);

  p_rx_off_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_i && op == 5'd3 |=> !rx_en);

  p_filter_load_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_i && op == 5'd16 |=> filt == $past(cmd_word_i[FILT_W-1:0]));

  p_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  p_busy_bound_r10: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_W'(BUSY_CYCLES));

  p_undef_stable_r12: assert property (@(posedge clk) disable iff (rst)
    undef |=> $stable(win) && $stable(rx_en) && $stable(filt) &&
              $stable(imask) && $stable(rzmask));
endmodule

bind nic_cmd_core nic_cmd_checker #(
  .CMD_W(CMD_W), .WIN_W(WIN_W), .EVT_W(EVT_W), .FILT_W(FILT_W),
  .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid_i), .cmd_word_i(cmd_word_i),
  .evt_i(evt_i), .win(win_q), .rx_en(rx_en_q), .filt(filt_q), .busy(busy),
  .pend(pend), .imask(imask), .rzmask(rzmask), .status(status_q)
);

// File: tb/nic_cmd_core_bench.sv
module nic_cmd_core_bench;
  localparam int CLK_P = 10;
  localparam int BC    = 5;
  localparam int NV    = 13;

  // {cmd[16], evt[8], expected status[16], expected irq[1]}
  localparam logic [40:0] VEC [NV] = '{
    {16'h0805, 8'h00, 16'hA000, 1'b0},  // R1 bank 5
    {16'h0FFB, 8'h00, 16'h6000, 1'b0},  // R13 upper arg ignored, bank 3
    {16'h4000, 8'h15, 16'h6014, 1'b0},  // R3 R12 events, bit0 ignored
    {16'h7010, 8'h00, 16'h6015, 1'b1},  // R5 enable RX done
    {16'h78EE, 8'h00, 16'h6004, 1'b1},  // R6 hide bits 4 and 0
    {16'h78FF, 8'h00, 16'h6015, 1'b1},  // R6 show all
    {16'h6811, 8'h00, 16'h6004, 1'b0},  // R4 ack bit4 (bit0 no effect)
    {16'h6000, 8'h00, 16'h6044, 1'b0},  // R8 host request
    {16'h7040, 8'h00, 16'h6045, 1'b1},  // R5 enable host request
    {16'h6844, 8'h04, 16'h6004, 1'b0},  // R3 set beats ack on bit2
    {16'h17FF, 8'h00, 16'h6004, 1'b0},  // R12 opcode 2
    {16'hFFFF, 8'h00, 16'h6004, 1'b0},  // R12 opcode 31
    {16'h88FF, 8'h00, 16'h6004, 1'b0}   // R12 opcode 17
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [7:0]  evt = '0;
  logic [2:0]  window;
  logic        rx_en;
  logic [3:0]  rx_filter;
  logic        busy;
  logic        irq;
  logic [15:0] status;
  int          n_chk = 0;
  int          n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  nic_cmd_core #(.BUSY_CYCLES(BC)) u_nic_cmd_core (
    .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid), .cmd_word_i(cmd_word),
    .evt_i(evt), .window_o(window), .rx_en_o(rx_en), .rx_filter_o(rx_filter),
    .busy_o(busy), .irq_o(irq), .status_o(status)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input logic [7:0] e);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = w; evt = e;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_word = '0; evt = '0;
  endtask

  task automatic settle();
    repeat (BC + 4) @(negedge clk);
  endtask

  task automatic busy_len(input string req, input logic [15:0] w);
    int n;
    send(w, 8'h00);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      if (busy) n++;
      @(negedge clk);
    end
    check(req, 16'(n), 16'(BC));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R2 reset status", status, 16'h0000);
    check("R1 reset bank", 16'(window), 16'h0);
    check("R9 reset rx", 16'(rx_en), 16'h0);
    check("R7 reset filter", 16'(rx_filter), 16'h0);
    check("R10 reset busy", 16'(busy), 16'h0);
    check("R5 reset irq", 16'(irq), 16'h0);

    for (int v = 0; v < NV; v++) begin
      send(VEC[v][40:25], VEC[v][24:17]);
      repeat (3) @(negedge clk);
      check($sformatf("R2 vec%0d status", v), status, VEC[v][16:1]);
      check($sformatf("R5 vec%0d irq", v), 16'(irq), 16'(VEC[v][0]));
    end

    // R7 filter, R13 upper argument bits ignored
    send(16'h87F5, 8'h00);
    repeat (2) @(negedge clk);
    check("R7 filter", 16'(rx_filter), 16'h5);

    // R9 receive enable and disable
    send(16'h2000, 8'h00);
    @(negedge clk);
    check("R9 rx on", 16'(rx_en), 16'h1);
    send(16'h1800, 8'h00);
    @(negedge clk);
    check("R9 rx off", 16'(rx_en), 16'h0);

    // R10 busy lengths
    busy_len("R10 busy op5", 16'h2800);
    busy_len("R10 busy op11", 16'h5800);
    send(16'h5800, 8'h00);
    @(negedge clk);
    check("R2 busy bit12 set", 16'(status[12]), 16'h1);
    settle();
    check("R2 busy bit12 clear", 16'(status[12]), 16'h0);

    // R10 restart while busy
    send(16'h2800, 8'h00);
    repeat (2) @(negedge clk);
    begin
      int n;
      send(16'h5800, 8'h00);
      n = 0;
      for (int i = 0; i < 20; i++) begin
        if (busy) n++;
        @(negedge clk);
      end
      check("R10 restart", 16'(n), 16'(BC));
    end

    // R11 global reset
    send(16'h0807, 8'h00);
    send(16'h70FF, 8'h00);
    send(16'h780F, 8'h00);
    send(16'h800F, 8'h00);
    send(16'h2000, 8'h00);
    send(16'h4000, 8'h08);
    repeat (3) @(negedge clk);
    check("R5 pre-reset irq", 16'(irq), 16'h1);
    send(16'h0000, 8'h00);
    settle();
    check("R11 status", status, 16'h0000);
    check("R11 bank", 16'(window), 16'h0);
    check("R11 filter", 16'(rx_filter), 16'h0);
    check("R11 rx", 16'(rx_en), 16'h0);
    check("R11 irq", 16'(irq), 16'h0);
    send(16'h4000, 8'h02);
    repeat (3) @(negedge clk);
    check("R11 masks reset status", status, 16'h0002);
    check("R11 masks reset irq", 16'(irq), 16'h0);

    finish_run();
  end
endmodule